// File: doc/BRIEF.md
# Store-to-Load Forwarding Checker

This block sits beside a store queue and decides, for each load that issues, how the load obtains its data. It scans the queued stores that are older than the load and sorts the outcome into one of three cases. If one store covers every byte the load reads, the load takes its bytes from that store. If a store covers only some of them and has not yet written back, the load must stall. If no relevant store overlaps, the load goes to memory. A load that bypasses the cache is rejected unless it is at the head of the load queue and ready to commit.

The store-queue contents are held in a register array inside the block and are loaded through a simple write port, one entry per cycle. Each load request produces one result, one cycle later: a 2-bit code and, for a forward, the extracted load data. When a load stalls, the block records the sequence numbers of the stalling store and load. The record stays in place until it is cleared or until an older load stalls.

Top module: `sfwd_checker`

## Requirements
- R1: Each cycle with `ld_req_i` high is followed, one clock later, by exactly one cycle with `res_valid_o` high. With no request, `res_valid_o` is low and `res_code_o` is 00.
- R2: A store entry takes part in the scan only if its sequence number is strictly lower than `ld_seq_i`, compared unsigned. Younger and equal entries are skipped.
- R3: An entry that is invalid, holds a byte count of zero, or is flagged committed is skipped during the scan.
- R4: The load range is [addr, addr+size) and the store range is [saddr, saddr+ssize). A full match holds when addr >= saddr and addr+size <= saddr+ssize. A full match gives code 01 and `fwd_data_o` = (store data >> 8*(addr AND (ssize-1))), keeping only the low 8*size bits and with the upper bits zero. Store data lane 0 is the byte at saddr.
- R5: A store whose range intersects the load range without full containment, and whose writeback has not completed, gives code 10 (stall).
- R6: A partially overlapping store whose writeback has completed is ignored. The scan carries on to older stores.
- R7: Among the stores that qualify, the one with the highest sequence number (the youngest of the older stores) decides the outcome.
- R8: If no store qualifies, the code is 00 (memory) and `fwd_data_o` is zero. `fwd_data_o` is zero for every code other than 01.
- R9: A load with `ld_uncached_i` high and `ld_at_head_i` low gives code 11 and leaves the stall record unchanged. An uncached load at the head is scanned as a normal load.
- R10: On a stall result, `stall_st_seq_o` and `stall_ld_seq_o` take the store and load sequence numbers, and `stall_pend_o` is set. This happens only if no stall is pending or the load's sequence number is lower than the recorded load's. `stall_clr_i` clears `stall_pend_o`, but a new recording in the same cycle takes precedence.
- R11: After reset every store entry is invalid, and all outputs are zero.
- R12: Sizes are byte counts. A store may have 0, 1, 2, 4 or 8 bytes and a load 1, 2, 4 or 8 bytes, with addresses aligned to their size. A write to the store array becomes visible to loads from the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sq_wr_en_i | input | 1 | Write one store-queue entry |
| sq_wr_idx_i | input | IDX_W | Entry index to write |
| sq_wr_valid_i | input | 1 | Entry holds a store |
| sq_wr_seq_i | input | SEQ_W | Store sequence number |
| sq_wr_addr_i | input | ADDR_W | Store byte address |
| sq_wr_size_i | input | 4 | Store byte count (0 = no data yet) |
| sq_wr_data_i | input | 64 | Store data, lane 0 at the store address |
| sq_wr_committed_i | input | 1 | Store is committed |
| sq_wr_done_i | input | 1 | Store writeback has completed |
| ld_req_i | input | 1 | Load issues this cycle |
| ld_addr_i | input | ADDR_W | Load byte address |
| ld_size_i | input | 4 | Load byte count |
| ld_seq_i | input | SEQ_W | Load sequence number |
| ld_uncached_i | input | 1 | Load bypasses the cache |
| ld_at_head_i | input | 1 | Load is at queue head and ready to commit |
| stall_clr_i | input | 1 | Clear the pending stall record |
| res_valid_o | output | 1 | Result valid |
| res_code_o | output | 2 | 00 memory, 01 forward, 10 stall, 11 uncached reject |
| fwd_data_o | output | 64 | Forwarded load data |
| stall_pend_o | output | 1 | A stall is recorded |
| stall_st_seq_o | output | SEQ_W | Recorded stalling store |
| stall_ld_seq_o | output | SEQ_W | Recorded stalled load |

## Verification
The result code and forwarded data are due on the first rising edge after the request. The stall record updates on that same edge. A store-array write takes effect on its own edge, so a load issued in the next cycle already sees it. The bench drives every input on the falling edge and lets one rising edge pass. It then samples code, data and stall record on the following falling edge, and compares them with a reference model updated at the same point. One cycle after the result it also checks that `res_valid_o` has dropped again.

// File: rtl/sfwd_pkg.sv
package sfwd_pkg;
  localparam int unsigned DATA_W = 64;
  localparam int unsigned SIZE_W = 4;

  typedef enum logic [1:0] {
    RES_MEM   = 2'b00,
    RES_FWD   = 2'b01,
    RES_STALL = 2'b10,
    RES_UNC   = 2'b11
  } res_e;

  function automatic logic [DATA_W-1:0] lane_mask(input logic [SIZE_W-1:0] nbytes);
    logic [DATA_W-1:0] m;
    m = '0;
    for (int b = 0; b < DATA_W/8; b++)
      if (b < int'(nbytes)) m[b*8 +: 8] = 8'hff;
    return m;
  endfunction
endpackage

// File: rtl/sfwd_store_array.sv
module sfwd_store_array
  import sfwd_pkg::*;
#(
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned SEQ_W  = 8,
  parameter int unsigned ADDR_W = 16,
  localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic              wr_valid_i,
  input  logic [SEQ_W-1:0]  wr_seq_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [SIZE_W-1:0] wr_size_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              wr_comm_i,
  input  logic              wr_done_i,
  output logic              valid_o [DEPTH],
  output logic [SEQ_W-1:0]  seq_o   [DEPTH],
  output logic [ADDR_W-1:0] addr_o  [DEPTH],
  output logic [SIZE_W-1:0] size_o  [DEPTH],
  output logic [DATA_W-1:0] data_o  [DEPTH],
  output logic              comm_o  [DEPTH],
  output logic              done_o  [DEPTH]
);
  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_o[g] <= 1'b0;
        seq_o[g]   <= '0;
        addr_o[g]  <= '0;
        size_o[g]  <= '0;
        data_o[g]  <= '0;
        comm_o[g]  <= 1'b0;
        done_o[g]  <= 1'b0;
      end else if (wr_en_i && wr_idx_i == IDX_W'(g)) begin
        valid_o[g] <= wr_valid_i;
        seq_o[g]   <= wr_seq_i;
        addr_o[g]  <= wr_addr_i;
        size_o[g]  <= wr_size_i;
        data_o[g]  <= wr_data_i;
        comm_o[g]  <= wr_comm_i;
        done_o[g]  <= wr_done_i;
      end
    end
  end
endmodule

// File: rtl/sfwd_match.sv
module sfwd_match
  import sfwd_pkg::*;
#(
  parameter int unsigned SEQ_W  = 8,
  parameter int unsigned ADDR_W = 16
) (
  input  logic              st_valid_i,
  input  logic [SEQ_W-1:0]  st_seq_i,
  input  logic [ADDR_W-1:0] st_addr_i,
  input  logic [SIZE_W-1:0] st_size_i,
  input  logic              st_comm_i,
  input  logic              st_done_i,
  input  logic [ADDR_W-1:0] ld_addr_i,
  input  logic [SIZE_W-1:0] ld_size_i,
  input  logic [SEQ_W-1:0]  ld_seq_i,
  output logic              cand_o,
  output logic              full_o
);
  localparam int unsigned EW = ADDR_W + 1;
  logic [EW-1:0] ld_lo, ld_hi, st_lo, st_hi;
  logic          elig, overlap, full;

  always_comb begin
    ld_lo   = {1'b0, ld_addr_i};
    ld_hi   = ld_lo + EW'(ld_size_i);
    st_lo   = {1'b0, st_addr_i};
    st_hi   = st_lo + EW'(st_size_i);
    elig    = st_valid_i && (st_size_i != '0) && !st_comm_i && (st_seq_i < ld_seq_i);
    overlap = (ld_lo < st_hi) && (ld_hi > st_lo);
    full    = (ld_lo >= st_lo) && (ld_hi <= st_hi);
    // completed partial overlaps drop out so older stores still count
    cand_o  = elig && overlap && (full || !st_done_i);
    full_o  = full;
  end
endmodule

// File: rtl/sfwd_select.sv
module sfwd_select
  import sfwd_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned SEQ_W = 8
) (
  input  logic              cand_i [DEPTH],
  input  logic              full_i [DEPTH],
  input  logic [SEQ_W-1:0]  seq_i  [DEPTH],
  input  logic [SIZE_W-1:0] size_i [DEPTH],
  input  logic [DATA_W-1:0] data_i [DEPTH],
  input  logic [2:0]        ld_ofs_i,
  input  logic [SIZE_W-1:0] ld_size_i,
  output logic              hit_o,
  output logic              hit_full_o,
  output logic [SEQ_W-1:0]  hit_seq_o,
  output logic [DATA_W-1:0] fwd_data_o
);
  logic [SIZE_W-1:0] sel_size;
  logic [DATA_W-1:0] sel_data;
  logic [SIZE_W-1:0] sz_m1;
  logic [2:0]        lane;

  always_comb begin
    hit_o      = 1'b0;
    hit_full_o = 1'b0;
    hit_seq_o  = '0;
    sel_size   = '0;
    sel_data   = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (cand_i[i] && (!hit_o || seq_i[i] > hit_seq_o)) begin
        hit_o      = 1'b1;
        hit_full_o = full_i[i];
        hit_seq_o  = seq_i[i];
        sel_size   = size_i[i];
        sel_data   = data_i[i];
      end
    end
    sz_m1      = sel_size - SIZE_W'(1);
    lane       = ld_ofs_i & sz_m1[2:0];
    fwd_data_o = (sel_data >> {lane, 3'b000}) & lane_mask(ld_size_i);
  end
endmodule

// File: rtl/sfwd_checker.sv
module sfwd_checker
  import sfwd_pkg::*;
#(
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned SEQ_W  = 8,
  parameter int unsigned ADDR_W = 16,
  localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sq_wr_en_i,
  input  logic [IDX_W-1:0]  sq_wr_idx_i,
  input  logic              sq_wr_valid_i,
  input  logic [SEQ_W-1:0]  sq_wr_seq_i,
  input  logic [ADDR_W-1:0] sq_wr_addr_i,
  input  logic [3:0]        sq_wr_size_i,
  input  logic [63:0]       sq_wr_data_i,
  input  logic              sq_wr_committed_i,
  input  logic              sq_wr_done_i,
  input  logic              ld_req_i,
  input  logic [ADDR_W-1:0] ld_addr_i,
  input  logic [3:0]        ld_size_i,
  input  logic [SEQ_W-1:0]  ld_seq_i,
  input  logic              ld_uncached_i,
  input  logic              ld_at_head_i,
  input  logic              stall_clr_i,
  output logic              res_valid_o,
  output logic [1:0]        res_code_o,
  output logic [63:0]       fwd_data_o,
  output logic              stall_pend_o,
  output logic [SEQ_W-1:0]  stall_st_seq_o,
  output logic [SEQ_W-1:0]  stall_ld_seq_o
);
  logic              e_valid [DEPTH];
  logic [SEQ_W-1:0]  e_seq   [DEPTH];
  logic [ADDR_W-1:0] e_addr  [DEPTH];
  logic [SIZE_W-1:0] e_size  [DEPTH];
  logic [DATA_W-1:0] e_data  [DEPTH];
  logic              e_comm  [DEPTH];
  logic              e_done  [DEPTH];
  logic              cand    [DEPTH];
  logic              full    [DEPTH];

  sfwd_store_array #(.DEPTH(DEPTH), .SEQ_W(SEQ_W), .ADDR_W(ADDR_W)) u_arr (
    .clk_i, .rst_ni,
    .wr_en_i(sq_wr_en_i), .wr_idx_i(sq_wr_idx_i), .wr_valid_i(sq_wr_valid_i),
    .wr_seq_i(sq_wr_seq_i), .wr_addr_i(sq_wr_addr_i), .wr_size_i(sq_wr_size_i),
    .wr_data_i(sq_wr_data_i), .wr_comm_i(sq_wr_committed_i), .wr_done_i(sq_wr_done_i),
    .valid_o(e_valid), .seq_o(e_seq), .addr_o(e_addr), .size_o(e_size),
    .data_o(e_data), .comm_o(e_comm), .done_o(e_done)
  );

  for (genvar g = 0; g < DEPTH; g++) begin : g_match
    sfwd_match #(.SEQ_W(SEQ_W), .ADDR_W(ADDR_W)) u_m (
      .st_valid_i(e_valid[g]), .st_seq_i(e_seq[g]), .st_addr_i(e_addr[g]),
      .st_size_i(e_size[g]), .st_comm_i(e_comm[g]), .st_done_i(e_done[g]),
      .ld_addr_i, .ld_size_i, .ld_seq_i,
      .cand_o(cand[g]), .full_o(full[g])
    );
  end

  logic              hit, hit_full;
  logic [SEQ_W-1:0]  hit_seq;
  logic [DATA_W-1:0] sel_data;

  sfwd_select #(.DEPTH(DEPTH), .SEQ_W(SEQ_W)) u_sel (
    .cand_i(cand), .full_i(full), .seq_i(e_seq), .size_i(e_size), .data_i(e_data),
    .ld_ofs_i(ld_addr_i[2:0]), .ld_size_i,
    .hit_o(hit), .hit_full_o(hit_full), .hit_seq_o(hit_seq), .fwd_data_o(sel_data)
  );

  res_e code_n;
  logic rec_stall;

  always_comb begin
    if (ld_uncached_i && !ld_at_head_i) code_n = RES_UNC;
    else if (!hit)                      code_n = RES_MEM;
    else if (hit_full)                  code_n = RES_FWD;
    else                                code_n = RES_STALL;
    rec_stall = ld_req_i && (code_n == RES_STALL) &&
                (!stall_pend_o || ld_seq_i < stall_ld_seq_o);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_valid_o <= 1'b0;
      res_code_o  <= RES_MEM;
      fwd_data_o  <= '0;
    end else begin
      res_valid_o <= ld_req_i;
      res_code_o  <= ld_req_i ? code_n : RES_MEM;
      fwd_data_o  <= (ld_req_i && code_n == RES_FWD) ? sel_data : '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stall_pend_o   <= 1'b0;
      stall_st_seq_o <= '0;
      stall_ld_seq_o <= '0;
    end else if (rec_stall) begin
      stall_pend_o   <= 1'b1;
      stall_st_seq_o <= hit_seq;
      stall_ld_seq_o <= ld_seq_i;
    end else if (stall_clr_i) begin
      stall_pend_o   <= 1'b0;
    end
  end

  a_r1_result_follows_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_req_i |=> res_valid_o);
  a_r1_no_spurious_result: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ld_req_i |=> !res_valid_o && res_code_o == RES_MEM);
  a_r2_hit_is_older: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_req_i && hit |-> hit_seq < ld_seq_i);
  a_r8_data_only_on_fwd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_code_o != RES_FWD |-> fwd_data_o == '0);
  a_r9_uncached_reject: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_req_i && ld_uncached_i && !ld_at_head_i && !stall_clr_i
      |=> res_code_o == RES_UNC && $stable(stall_pend_o) && $stable(stall_ld_seq_o));
  a_r10_record_on_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stall_pend_o) |-> res_valid_o && res_code_o == RES_STALL);
endmodule

// File: tb/sim_sfwd_checker.sv
`timescale 1ns/1ps
module sim_sfwd_checker;
  localparam int DEPTH = 8;
  localparam int SEQ_W = 8;
  localparam int ADDR_W = 16;

  logic clk = 0, rst_n = 0;
  always #4 clk = ~clk;

  logic        sq_wr_en = 0, sq_wr_valid = 0, sq_wr_comm = 0, sq_wr_done = 0;
  logic [2:0]  sq_wr_idx = 0;
  logic [7:0]  sq_wr_seq = 0;
  logic [15:0] sq_wr_addr = 0;
  logic [3:0]  sq_wr_size = 0;
  logic [63:0] sq_wr_data = 0;
  logic        ld_req = 0, ld_unc = 0, ld_head = 0, stall_clr = 0;
  logic [15:0] ld_addr = 0;
  logic [3:0]  ld_size = 0;
  logic [7:0]  ld_seq = 0;
  logic        res_valid, stall_pend;
  logic [1:0]  res_code;
  logic [63:0] fwd_data;
  logic [7:0]  stall_st, stall_ld;

  sfwd_checker #(.DEPTH(DEPTH), .SEQ_W(SEQ_W), .ADDR_W(ADDR_W)) u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .sq_wr_en_i(sq_wr_en), .sq_wr_idx_i(sq_wr_idx), .sq_wr_valid_i(sq_wr_valid),
    .sq_wr_seq_i(sq_wr_seq), .sq_wr_addr_i(sq_wr_addr), .sq_wr_size_i(sq_wr_size),
    .sq_wr_data_i(sq_wr_data), .sq_wr_committed_i(sq_wr_comm), .sq_wr_done_i(sq_wr_done),
    .ld_req_i(ld_req), .ld_addr_i(ld_addr), .ld_size_i(ld_size), .ld_seq_i(ld_seq),
    .ld_uncached_i(ld_unc), .ld_at_head_i(ld_head), .stall_clr_i(stall_clr),
    .res_valid_o(res_valid), .res_code_o(res_code), .fwd_data_o(fwd_data),
    .stall_pend_o(stall_pend), .stall_st_seq_o(stall_st), .stall_ld_seq_o(stall_ld)
  );

  int checks = 0, errors = 0;
  bit done = 0;

  // reference model
  bit          m_valid [DEPTH];
  int          m_seq   [DEPTH];
  int          m_addr  [DEPTH];
  int          m_size  [DEPTH];
  logic [63:0] m_data  [DEPTH];
  bit          m_comm  [DEPTH];
  bit          m_done  [DEPTH];
  bit m_pend = 0;
  int m_st = 0, m_ld = 0;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_store(input int idx, input bit v, input int seq, input int addr,
                          input int size, input logic [63:0] data, input bit comm, input bit dn);
    @(negedge clk);
    sq_wr_en = 1; sq_wr_idx = 3'(idx); sq_wr_valid = v; sq_wr_seq = 8'(seq);
    sq_wr_addr = 16'(addr); sq_wr_size = 4'(size); sq_wr_data = data;
    sq_wr_comm = comm; sq_wr_done = dn;
    @(posedge clk);
    m_valid[idx] = v; m_seq[idx] = seq; m_addr[idx] = addr; m_size[idx] = size;
    m_data[idx] = data; m_comm[idx] = comm; m_done[idx] = dn;
    @(negedge clk);
    sq_wr_en = 0;
  endtask

  // expected code and data from the requirements
  task automatic model(input int addr, input int size, input int seq, input bit unc,
                       input bit head, output int code, output logic [63:0] data, output int st);
    int best = -1;
    bit bfull = 0;
    code = 0; data = 0; st = 0;
    if (unc && !head) begin code = 3; return; end
    for (int i = 0; i < DEPTH; i++) begin
      bit ov, fl;
      if (!m_valid[i] || m_size[i] == 0 || m_comm[i] || m_seq[i] >= seq) continue;
      ov = addr < m_addr[i] + m_size[i] && addr + size > m_addr[i];
      fl = addr >= m_addr[i] && addr + size <= m_addr[i] + m_size[i];
      if (!ov || (!fl && m_done[i])) continue;
      if (best < 0 || m_seq[i] > m_seq[best]) begin best = i; bfull = fl; end
    end
    if (best < 0) return;
    st = m_seq[best];
    if (!bfull) begin code = 2; return; end
    code = 1;
    begin
      int sh = (addr % m_size[best]) * 8;
      logic [63:0] msk = (size == 8) ? '1 : ((64'h1 << (size * 8)) - 1);
      data = (m_data[best] >> sh) & msk;
    end
  endtask

  task automatic do_load(input string req, input int addr, input int size, input int seq,
                         input bit unc, input bit head, input bit clr);
    int code, st;
    logic [63:0] data;
    model(addr, size, seq, unc, head, code, data, st);
    @(negedge clk);
    ld_req = 1; ld_addr = 16'(addr); ld_size = 4'(size); ld_seq = 8'(seq);
    ld_unc = unc; ld_head = head; stall_clr = clr;
    @(posedge clk);
    if (code == 2 && (!m_pend || seq < m_ld)) begin m_pend = 1; m_st = st; m_ld = seq; end
    else if (clr) m_pend = 0;
    @(negedge clk);
    ld_req = 0; stall_clr = 0;
    chk({req, " R1 valid"}, 64'(res_valid), 64'd1);
    chk({req, " code"}, 64'(res_code), 64'(code));
    chk({req, " data"}, fwd_data, data);
    chk({req, " R10 pend"}, 64'(stall_pend), 64'(m_pend));
    if (m_pend) begin
      chk({req, " R10 st"}, 64'(stall_st), 64'(m_st));
      chk({req, " R10 ld"}, 64'(stall_ld), 64'(m_ld));
    end
    @(posedge clk);
    @(negedge clk);
    chk({req, " R1 drop"}, {63'd0, res_valid}, 64'd0);
  endtask

  task automatic clear_stall();
    @(negedge clk);
    stall_clr = 1;
    @(posedge clk);
    m_pend = 0;
    @(negedge clk);
    stall_clr = 0;
    chk("R10 clear", 64'(stall_pend), 64'd0);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int sizes_st [5] = '{0, 1, 2, 4, 8};
    int sizes_ld [4] = '{1, 2, 4, 8};
    void'($urandom(32'h5eed1));
    for (int i = 0; i < DEPTH; i++) begin
      m_valid[i] = 0; m_seq[i] = 0; m_addr[i] = 0; m_size[i] = 0;
      m_data[i] = 0; m_comm[i] = 0; m_done[i] = 0;
    end
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 valid", 64'(res_valid), 64'd0);
    chk("R11 code", 64'(res_code), 64'd0);
    chk("R11 pend", 64'(stall_pend), 64'd0);
    chk("R11 data", fwd_data, 64'd0);
    rst_n = 1;
    do_load("R11 R8 empty", 8, 4, 100, 0, 0, 0);

    // R4 / R12 full containment with lane shift
    wr_store(0, 1, 10, 8, 8, 64'h1122334455667788, 0, 0);
    do_load("R4 fwd", 10, 2, 20, 0, 0, 0);
    do_load("R4 fwd8", 8, 8, 20, 0, 0, 0);
    do_load("R2 younger", 10, 2, 5, 0, 0, 0);
    do_load("R2 equal", 10, 2, 10, 0, 0, 0);
    // R5 partial stall and R10 record
    wr_store(1, 1, 12, 16, 2, 64'hbeef, 0, 0);
    do_load("R5 stall", 16, 4, 20, 0, 0, 0);
    do_load("R10 younger keeps", 16, 4, 30, 0, 0, 0);
    do_load("R10 older replaces", 16, 4, 15, 0, 0, 0);
    clear_stall();
    // R6 completed partial ignored, scan continues
    wr_store(1, 1, 12, 16, 2, 64'hbeef, 0, 1);
    do_load("R6 ignored", 16, 4, 20, 0, 0, 0);
    wr_store(2, 1, 11, 16, 8, 64'h0807060504030201, 0, 0);
    do_load("R6 older fwd", 16, 4, 20, 0, 0, 0);
    // R7 youngest older wins
    wr_store(3, 1, 14, 8, 4, 64'hcafef00d, 0, 0);
    do_load("R7 youngest", 8, 2, 20, 0, 0, 0);
    do_load("R7 between", 8, 2, 13, 0, 0, 0);
    // R3 committed and zero size skipped
    wr_store(3, 1, 14, 8, 4, 64'hcafef00d, 1, 0);
    do_load("R3 committed", 8, 2, 20, 0, 0, 0);
    wr_store(0, 1, 10, 8, 0, 64'h1122334455667788, 0, 0);
    do_load("R3 size0", 8, 2, 20, 0, 0, 0);
    wr_store(0, 0, 10, 8, 8, 64'h1122334455667788, 0, 0);
    do_load("R3 invalid", 8, 2, 20, 0, 0, 0);
    // R9 uncached
    wr_store(4, 1, 40, 32, 4, 64'h0, 0, 0);
    do_load("R9 reject", 32, 8, 50, 1, 0, 0);
    do_load("R9 at head", 32, 8, 50, 1, 1, 0);
    do_load("R9 reject keeps", 32, 8, 45, 1, 0, 0);
    clear_stall();

    // random mix
    for (int n = 0; n < 600; n++) begin
      if ($urandom % 3 == 0) begin
        int idx = int'($urandom % DEPTH);
        int sz = sizes_st[$urandom % 5];
        int ad = int'($urandom % 32);
        if (sz > 0) ad = ad - (ad % sz);
        wr_store(idx, ($urandom % 6) != 0, int'($urandom % 32) * 8 + idx, ad, sz,
                 {$urandom, $urandom}, ($urandom % 5) == 0, ($urandom % 3) == 0);
      end else begin
        int sz = sizes_ld[$urandom % 4];
        int ad = int'($urandom % 32);
        ad = ad - (ad % sz);
        do_load("R4-R10 random", ad, sz, int'($urandom % 256), ($urandom % 8) == 0,
                ($urandom % 2) == 0, ($urandom % 6) == 0);
      end
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule